// File: doc/BRIEF.md
# 4x4 Coefficient Block Quantizer

This block turns one 4x4 block of signed transform coefficients into signed quantized levels. Each of the 16 positions has a rounding offset and a multiplier. The offset is added to the coefficient's magnitude, the sum is multiplied, and the upper half of the product becomes the level's magnitude. The coefficient's sign is then put back on the result. Two per-block summaries come with the levels: the number of nonzero levels and the largest magnitude.

A block can arrive in two ways. In parallel form all sixteen coefficients arrive on one accepted beat. In raster form one coefficient arrives per beat, position 0 first. Offsets and multipliers come from two 8-entry tables, and each table is used twice over the block. A DC mode replaces both tables with one scalar offset and one scalar multiplier for every position. A batch flag groups four consecutive blocks, and the four block peaks are then reported together in block order.

Top module: `coef_quant4x4`

## Requirements
- R1: The magnitude of a nonzero coefficient c is q = ((ofs + |c|) * mul) >> 16. Both ofs and mul are unsigned 16-bit values, and the sum is formed in 17 bits so that it never wraps.
- R2: When the shifted product exceeds 32767, q saturates to 32767.
- R3: The level is +q when c > 0 and -q (two's complement) when c < 0. A zero coefficient yields a zero level and a zero magnitude whatever the tables hold.
- R4: Coefficient p (raster order, in_coef_i bits [16p+15:16p]) uses table entry p mod 8. Entry e sits at bits [16e+15:16e] of ofs_tab_i and of mul_tab_i.
- R5: When dc_mode_i is high on the launching beat, dc_ofs_i and dc_mul_i are applied to all 16 positions and both tables are ignored.
- R6: out_nz_o equals 16 minus the number of levels that are exactly zero.
- R7: out_peak_o is the unsigned maximum of the 16 magnitudes q. It is taken before the sign is restored.
- R8: A block launched at clock edge k appears on out_level_o, out_nz_o and out_peak_o after edge k+1. out_valid_o is high for exactly that one cycle.
- R9: With in_serial_i high, every valid beat is accepted and carries one coefficient on in_ser_coef_i, position 0 first. The 16th beat launches the block. The tables, mode and batch flag are sampled on that beat.
- R10: While a raster block is partly collected, a beat with in_serial_i low is refused: in_ready_o is low and the beat changes neither the collected data nor the outputs.
- R11: Four consecutive blocks launched with batch_i high raise out_batch_valid_o together with the fourth block's outputs. out_batch_peak_o then holds block j's peak at bits [16j+15:16j]. A block launched with batch_i low restarts the grouping.
- R12: After reset out_valid_o and out_batch_valid_o are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| in_serial_i | input | 1 | 1: raster one-per-beat, 0: whole block per beat |
| in_coef_i | input | 256 | Parallel coefficients, position p at [16p+15:16p] |
| in_ser_coef_i | input | 16 | Raster coefficient |
| dc_mode_i | input | 1 | Use scalar offset and multiplier |
| dc_ofs_i | input | 16 | Scalar offset |
| dc_mul_i | input | 16 | Scalar multiplier |
| ofs_tab_i | input | 128 | Eight offsets |
| mul_tab_i | input | 128 | Eight multipliers |
| batch_i | input | 1 | Block belongs to a four-block group |
| out_valid_o | output | 1 | Block result valid |
| out_level_o | output | 256 | Signed levels, position p at [16p+15:16p] |
| out_nz_o | output | 5 | Nonzero level count |
| out_peak_o | output | 16 | Largest magnitude |
| out_batch_valid_o | output | 1 | Four-block group complete |
| out_batch_peak_o | output | 64 | Block peaks in block order |

## Verification
The hardest state to reach from the ports is a parallel beat arriving while a raster block is only partly collected. The bench sends five raster beats, then presents a parallel beat carrying unrelated data. It checks that in_ready_o is low and that no result appears, then finishes the raster block and compares every level against the raster data alone. Batch grouping is also exercised past a restart: a non-batch block in the middle of a group must push the group report out to the fourth batch block after it. Saturation is reached by driving full-scale offsets and multipliers together with the extreme coefficients -32768 and +32767.

// File: rtl/qnt_pkg.sv
package qnt_pkg;
  localparam int unsigned COEF_W  = 16;
  localparam int unsigned TAB_W   = 16;
  localparam int unsigned N_POS   = 16;
  localparam int unsigned TAB_N   = 8;
  localparam int unsigned SHIFT   = 16;
  localparam int unsigned BATCH_N = 4;
endpackage

// File: rtl/qnt_lane.sv
module qnt_lane #(
  parameter int unsigned CW = 16,
  parameter int unsigned TW = 16,
  parameter int unsigned SH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] coef_i,
  input  logic [TW-1:0] ofs_i,
  input  logic [TW-1:0] mul_i,
  output logic [CW-2:0] mag_o,
  output logic          neg_o
);
  localparam int unsigned MW     = CW - 1;
  localparam int unsigned SUM_W  = ((TW > CW) ? TW : CW) + 1;
  localparam int unsigned PROD_W = SUM_W + TW;
  localparam logic [PROD_W-1:0] QMAX = PROD_W'((64'd1 << MW) - 1);

  logic              is_neg, is_zero;
  logic [CW-1:0]     abs_c;
  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod, shifted;
  logic [MW-1:0]     q_sat;
  logic [MW-1:0]     mag_q;
  logic              neg_q;

  always_comb begin
    is_neg  = coef_i[CW-1];
    is_zero = (coef_i == '0);
    abs_c   = is_neg ? (~coef_i + CW'(1)) : coef_i;  // -min maps to 2^(CW-1) unsigned
    sum     = SUM_W'(abs_c) + SUM_W'(ofs_i);
    prod    = PROD_W'(sum) * PROD_W'(mul_i);
    shifted = prod >> SH;
    q_sat   = (shifted > QMAX) ? QMAX[MW-1:0] : shifted[MW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else if (en_i) begin
      mag_q <= is_zero ? '0 : q_sat;
      neg_q <= is_neg;
    end
  end

  assign mag_o = mag_q;
  assign neg_o = neg_q;

  // R3
  zero_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && coef_i == '0) |=> (mag_o == '0));

endmodule

// File: rtl/qnt_collect.sv
module qnt_collect #(
  parameter int unsigned N  = 16,
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            serial_i,
  input  logic [N*CW-1:0] par_coef_i,
  input  logic [CW-1:0]   ser_coef_i,
  output logic            ready_o,
  output logic            launch_o,
  output logic [N*CW-1:0] coef_o
);
  localparam int unsigned FW = $clog2(N);
  localparam logic [FW-1:0] LAST = FW'(N - 1);

  logic [FW-1:0] fill_q;
  logic [CW-1:0] buf_q [N-1];
  logic          ser_take, at_last;

  assign ser_take = valid_i && serial_i;
  assign at_last  = (fill_q == LAST);
  assign ready_o  = serial_i || (fill_q == '0);
  assign launch_o = (valid_i && !serial_i && fill_q == '0) || (ser_take && at_last);

  for (genvar p = 0; p < N - 1; p++) begin : g_sel
    assign coef_o[p*CW +: CW] = serial_i ? buf_q[p] : par_coef_i[p*CW +: CW];
  end
  assign coef_o[(N-1)*CW +: CW] = serial_i ? ser_coef_i : par_coef_i[(N-1)*CW +: CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < N - 1; i++) buf_q[i] <= '0;
    end else if (ser_take) begin
      if (at_last) begin
        fill_q <= '0;
      end else begin
        buf_q[fill_q] <= ser_coef_i;
        fill_q        <= fill_q + FW'(1);
      end
    end
  end

  // R10
  par_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !serial_i && fill_q != '0) |=> $stable(fill_q));

endmodule

// File: rtl/qnt_reduce.sv
module qnt_reduce #(
  parameter int unsigned N     = 16,
  parameter int unsigned MW    = 15,
  parameter int unsigned CNT_W = $clog2(N + 1)
) (
  input  logic [N*MW-1:0] mag_i,
  output logic [CNT_W-1:0] nz_o,
  output logic [MW-1:0]    peak_o
);
  always_comb begin
    nz_o   = '0;
    peak_o = '0;
    for (int p = 0; p < N; p++) begin
      if (mag_i[p*MW +: MW] != '0) nz_o = nz_o + CNT_W'(1);
      if (mag_i[p*MW +: MW] > peak_o) peak_o = mag_i[p*MW +: MW];
    end
  end
endmodule

// File: rtl/coef_quant4x4.sv
module coef_quant4x4
  import qnt_pkg::*;
#(
  parameter int unsigned CW      = COEF_W,
  parameter int unsigned TW      = TAB_W,
  parameter int unsigned N       = N_POS,
  parameter int unsigned TN      = TAB_N,
  parameter int unsigned SH      = SHIFT,
  parameter int unsigned BN      = BATCH_N,
  parameter int unsigned CNT_W   = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_serial_i,
  input  logic [N*CW-1:0]   in_coef_i,
  input  logic [CW-1:0]     in_ser_coef_i,
  input  logic              dc_mode_i,
  input  logic [TW-1:0]     dc_ofs_i,
  input  logic [TW-1:0]     dc_mul_i,
  input  logic [TN*TW-1:0]  ofs_tab_i,
  input  logic [TN*TW-1:0]  mul_tab_i,
  input  logic              batch_i,
  output logic              out_valid_o,
  output logic [N*CW-1:0]   out_level_o,
  output logic [CNT_W-1:0]  out_nz_o,
  output logic [CW-1:0]     out_peak_o,
  output logic              out_batch_valid_o,
  output logic [BN*CW-1:0]  out_batch_peak_o
);
  localparam int unsigned MW = CW - 1;
  localparam int unsigned BW = (BN > 1) ? $clog2(BN) : 1;
  localparam logic [BW-1:0] B_LAST = BW'(BN - 1);

  logic            launch;
  logic [N*CW-1:0] coef_l;
  logic [N*MW-1:0] mag_s1;
  logic [N-1:0]    neg_s1;
  logic            s1_v, s1_batch;
  logic [CNT_W-1:0] nz_c;
  logic [MW-1:0]   peak_c;

  qnt_collect #(.N(N), .CW(CW)) u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .serial_i   (in_serial_i),
    .par_coef_i (in_coef_i),
    .ser_coef_i (in_ser_coef_i),
    .ready_o    (in_ready_o),
    .launch_o   (launch),
    .coef_o     (coef_l)
  );

  for (genvar p = 0; p < N; p++) begin : g_lane
    localparam int unsigned SEL = p % TN;
    logic [TW-1:0] ofs_p, mul_p;
    assign ofs_p = dc_mode_i ? dc_ofs_i : ofs_tab_i[SEL*TW +: TW];
    assign mul_p = dc_mode_i ? dc_mul_i : mul_tab_i[SEL*TW +: TW];
    qnt_lane #(.CW(CW), .TW(TW), .SH(SH)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (launch),
      .coef_i (coef_l[p*CW +: CW]),
      .ofs_i  (ofs_p),
      .mul_i  (mul_p),
      .mag_o  (mag_s1[p*MW +: MW]),
      .neg_o  (neg_s1[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v     <= 1'b0;
      s1_batch <= 1'b0;
    end else begin
      s1_v <= launch;
      if (launch) s1_batch <= batch_i;
    end
  end

  qnt_reduce #(.N(N), .MW(MW), .CNT_W(CNT_W)) u_reduce (
    .mag_i  (mag_s1),
    .nz_o   (nz_c),
    .peak_o (peak_c)
  );

  // output stage
  logic [N*CW-1:0]  level_q;
  logic [CNT_W-1:0] nz_q;
  logic [CW-1:0]    peak_q;
  logic             valid_q, bvalid_q;
  logic [BW-1:0]    bcnt_q;
  logic [CW-1:0]    bpeak_q [BN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      nz_q    <= '0;
      peak_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= s1_v;
      if (s1_v) begin
        for (int p = 0; p < N; p++) begin
          level_q[p*CW +: CW] <= neg_s1[p] ? (CW'(0) - {1'b0, mag_s1[p*MW +: MW]})
                                            : {1'b0, mag_s1[p*MW +: MW]};
        end
        nz_q   <= nz_c;
        peak_q <= {1'b0, peak_c};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q   <= '0;
      bvalid_q <= 1'b0;
      for (int b = 0; b < BN; b++) bpeak_q[b] <= '0;
    end else begin
      bvalid_q <= 1'b0;
      if (s1_v) begin
        if (s1_batch) begin
          bpeak_q[bcnt_q] <= {1'b0, peak_c};
          if (bcnt_q == B_LAST) begin
            bcnt_q   <= '0;
            bvalid_q <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + BW'(1);
          end
        end else begin
          bcnt_q <= '0;
        end
      end
    end
  end

  assign out_valid_o       = valid_q;
  assign out_level_o       = level_q;
  assign out_nz_o          = nz_q;
  assign out_peak_o        = peak_q;
  assign out_batch_valid_o = bvalid_q;
  for (genvar b = 0; b < BN; b++) begin : g_bpk
    assign out_batch_peak_o[b*CW +: CW] = bpeak_q[b];
  end

  // R8
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v |=> out_valid_o);

  // R8
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_v |=> !out_valid_o);

  // R11
  batch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_batch_valid_o |-> out_valid_o);

  // R7
  peak_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_nz_o == '0) |-> (out_peak_o == '0));

  // R6
  full_nz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_nz_o == CNT_W'(N)) |-> (out_peak_o != '0));

endmodule

// File: tb/coef_quant4x4_bench.sv
module coef_quant4x4_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         in_valid, in_ready, in_serial, dc_mode, batch;
  logic [255:0] in_coef;
  logic [15:0]  in_ser_coef, dc_ofs, dc_mul;
  logic [127:0] ofs_tab, mul_tab;
  logic         out_valid, out_bvalid;
  logic [255:0] out_level;
  logic [4:0]   out_nz;
  logic [15:0]  out_peak;
  logic [63:0]  out_bpeak;

  coef_quant4x4 u_coef_quant4x4 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_serial_i(in_serial), .in_coef_i(in_coef), .in_ser_coef_i(in_ser_coef),
    .dc_mode_i(dc_mode), .dc_ofs_i(dc_ofs), .dc_mul_i(dc_mul),
    .ofs_tab_i(ofs_tab), .mul_tab_i(mul_tab), .batch_i(batch),
    .out_valid_o(out_valid), .out_level_o(out_level), .out_nz_o(out_nz),
    .out_peak_o(out_peak), .out_batch_valid_o(out_bvalid), .out_batch_peak_o(out_bpeak)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] coef [16];
  int last_peak;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_mag(input int c, input int ff, input int mf);
    longint a, p;
    if (c == 0) return 0;
    a = (c < 0) ? -c : c;
    p = ((a + ff) * mf) >>> 16;
    if (p > 32767) p = 32767;
    return int'(p);
  endfunction

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  // check outputs against the bench model, called at the result negedge
  task automatic check_block(input string req);
    int ff, mf, m, exp_l, nz, pk, bad_p, bad_a, bad_e;
    nz = 0; pk = 0; bad_p = -1; bad_a = 0; bad_e = 0;
    chk(out_valid === 1'b1, req, "out_valid", out_valid, 1);
    for (int p = 0; p < 16; p++) begin
      ff = dc_mode ? int'(dc_ofs) : int'(ofs_tab[(p%8)*16 +: 16]);
      mf = dc_mode ? int'(dc_mul) : int'(mul_tab[(p%8)*16 +: 16]);
      m  = ref_mag(sx(coef[p]), ff, mf);
      exp_l = (sx(coef[p]) < 0) ? -m : m;
      if (m != 0) nz++;
      if (m > pk) pk = m;
      if (sx(out_level[p*16 +: 16]) != exp_l && bad_p < 0) begin
        bad_p = p; bad_a = sx(out_level[p*16 +: 16]); bad_e = exp_l;
      end
    end
    chk(bad_p < 0, req, $sformatf("level[%0d]", bad_p), bad_a, bad_e);
    chk(int'(out_nz) == nz, "R6", "nz count", out_nz, nz);
    chk(int'(out_peak) == pk, "R7", "peak", out_peak, pk);
    last_peak = pk;
  endtask

  task automatic rand_tables();
    for (int e = 0; e < 8; e++) begin
      ofs_tab[e*16 +: 16] = 16'($urandom_range(0, 2000));
      mul_tab[e*16 +: 16] = 16'($urandom);
    end
  endtask

  task automatic send_par(input string req);
    @(negedge clk);
    for (int p = 0; p < 16; p++) in_coef[p*16 +: 16] = coef[p];
    in_serial = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_block(req);
  endtask

  task automatic send_ser(input string req);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      in_serial = 1'b1; in_valid = 1'b1; in_ser_coef = coef[p];
    end
    @(negedge clk);
    in_valid = 1'b0; in_serial = 1'b0;
    @(negedge clk);
    check_block(req);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(out_bvalid === 1'b0, "R12", "batch_valid after reset", out_bvalid, 0);
    chk(in_ready === 1'b1, "R12", "ready after reset", in_ready, 1);
  endtask

  task automatic t_random(); // R1 R4
    for (int k = 0; k < 20; k++) begin
      rand_tables();
      for (int p = 0; p < 16; p++) coef[p] = 16'($urandom);
      send_par("R1/R4 random");
    end
  endtask

  task automatic t_extremes(); // R3
    logic [15:0] pat [6];
    pat[0] = 16'h8000; pat[1] = 16'h7fff; pat[2] = 16'h0000;
    pat[3] = 16'hffff; pat[4] = 16'h0001; pat[5] = 16'h8001;
    for (int k = 0; k < 6; k++) begin
      rand_tables();
      for (int p = 0; p < 16; p++) coef[p] = pat[(p + k) % 6];
      send_par("R3 extremes");
    end
  endtask

  task automatic t_sat(); // R2
    for (int e = 0; e < 8; e++) begin
      ofs_tab[e*16 +: 16] = 16'hffff; mul_tab[e*16 +: 16] = 16'hffff;
    end
    for (int p = 0; p < 16; p++) coef[p] = (p % 2) ? 16'h7fff : 16'h8000;
    send_par("R2 saturation");
    chk(out_peak == 16'd32767, "R2", "saturated peak", out_peak, 32767);
    chk(sx(out_level[15:0]) == -32767, "R2", "negative saturated level",
        sx(out_level[15:0]), -32767);
  endtask

  task automatic t_zero(); // R3 R6
    for (int e = 0; e < 8; e++) begin
      ofs_tab[e*16 +: 16] = 16'hffff; mul_tab[e*16 +: 16] = 16'hffff;
    end
    for (int p = 0; p < 16; p++) coef[p] = 16'h0000;
    send_par("R3 zero block");
    chk(out_nz == 5'd0, "R6", "zero block count", out_nz, 0);
    chk(out_level == '0, "R3", "zero block levels nonzero", out_level != '0, 0);
  endtask

  task automatic t_dc(); // R5
    dc_mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      rand_tables();
      dc_ofs = 16'($urandom_range(0, 768));
      dc_mul = 16'($urandom);
      for (int p = 0; p < 16; p++) coef[p] = 16'($urandom);
      send_par("R5 dc mode");
    end
    dc_mode = 1'b0;
  endtask

  task automatic t_serial(); // R9
    for (int k = 0; k < 3; k++) begin
      rand_tables();
      for (int p = 0; p < 16; p++) coef[p] = 16'($urandom);
      send_ser("R9 serial");
    end
  endtask

  task automatic t_refuse(); // R10
    rand_tables();
    for (int p = 0; p < 16; p++) coef[p] = 16'($urandom);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      in_serial = 1'b1; in_valid = 1'b1; in_ser_coef = coef[p];
    end
    @(negedge clk);
    in_serial = 1'b0; in_valid = 1'b1;
    in_coef = {16{16'h1234}};
    #1;
    chk(in_ready === 1'b0, "R10", "ready during partial serial", in_ready, 0);
    for (int p = 5; p < 16; p++) begin
      @(negedge clk);
      if (p == 7) chk(out_valid === 1'b0, "R10", "refused beat made output", out_valid, 0);
      in_serial = 1'b1; in_valid = 1'b1; in_ser_coef = coef[p];
    end
    @(negedge clk);
    in_valid = 1'b0; in_serial = 1'b0;
    @(negedge clk);
    check_block("R10 after refused beat");
  endtask

  task automatic t_batch(); // R11
    int pk [4];
    rand_tables();
    batch = 1'b1;
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 16; p++) coef[p] = 16'($urandom_range(0, 4000 * (b + 1)));
      send_par("R11 batch block");
      pk[b] = last_peak;
      chk(out_bvalid === (b == 3), "R11", $sformatf("batch_valid at block %0d", b),
          out_bvalid, b == 3);
    end
    for (int b = 0; b < 4; b++)
      chk(int'(out_bpeak[b*16 +: 16]) == pk[b], "R11", $sformatf("batch peak %0d", b),
          out_bpeak[b*16 +: 16], pk[b]);
    // restart: two batch, one plain, then four batch
    for (int k = 0; k < 7; k++) begin
      batch = (k != 2);
      for (int p = 0; p < 16; p++) coef[p] = 16'($urandom);
      send_par("R11 restart");
      chk(out_bvalid === (k == 6), "R11", $sformatf("batch_valid after restart step %0d", k),
          out_bvalid, k == 6);
    end
    batch = 1'b0;
  endtask

  initial begin
    in_valid = 0; in_serial = 0; dc_mode = 0; batch = 0;
    in_coef = '0; in_ser_coef = '0; dc_ofs = '0; dc_mul = '0;
    ofs_tab = '0; mul_tab = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_extremes();
    t_sat();
    t_zero();
    t_dc();
    t_serial();
    t_refuse();
    t_batch();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule